// File: doc/BRIEF.md
# Fixed-Cycle Countdown Timer with Interrupt

This block is the periodic timer of a real-time clock. Software writes a preset count and a small control word, and the block then counts down once per pulse of a source tick. When the count runs out, the block loads the preset again, so expiries repeat at a fixed period for as long as the timer is enabled. Each expiry sets a sticky event flag. If interrupts are enabled, each expiry also asserts an active-low open-drain interrupt.

The interrupt output is modelled as an active-low output enable. It is driven when the timer's own interrupt is pending or when another interrupt source in the chip raises `extIrq`. A timer interrupt releases itself after at least one full period of a 128 Hz tick. Software can also cancel it by writing the interrupt-enable bit to 0. Clearing the event flag has no effect on the interrupt.

The register writes use a single-cycle strobe with a 2-bit address:

| Address | Contents |
|---------|----------|
| 0 | Preset count |
| 1 | Control word |
| 2 | Flag write, bit 0 |

The control word has four bits:

| Bit | Name | Kind | Meaning |
|-----|------|------|---------|
| 0 | enable | stored | Timer enabled |
| 1 | run | stored | 1 counts, 0 pauses |
| 2 | reload | strobe, not stored | Loads the preset into the counter |
| 3 | interrupt enable | stored | Expiries may assert the interrupt |

Top module: `fixed_cycle_timer`

## Requirements
- R1: After reset the count is 0, the event flag is 0, the timer interrupt is 0, and `intOeN` is 1 while `extIrq` is 0.
- R2: While enable (control bit 0) and run (control bit 1) are both 1, each `srcTick` lowers the count by one. A tick that arrives while the count is 1 is an expiry, and the count becomes the preset on that edge.
- R3: While run is 0, the count holds its value through any number of `srcTick` pulses and is not reset. A new run value takes effect from the cycle after the write.
- R4: A control write with bit 2 set loads the preset into the counter on that edge, and takes priority over a coincident tick. Bit 2 is not stored.
- R5: While enable is 0, the count equals the preset, including a preset written in that same cycle. After enable goes from 0 to 1, counting always starts from the preset.
- R6: An expiry sets the event flag. The flag then stays 1 until a write to address 2 with bit 0 equal to 0. A write there with bit 0 equal to 1 is ignored.
- R7: An expiry asserts the timer interrupt only if interrupt enable (control bit 3) is 1.
- R8: An asserted timer interrupt stays on through the first `hzTick` and is released on the second `hzTick`.
- R9: Clearing the event flag does not release an asserted timer interrupt.
- R10: A control write with bit 3 equal to 0 releases the timer interrupt on that edge.
- R11: `intOeN` is 0 whenever the timer interrupt or `extIrq` is 1, and 1 otherwise.
- R12: A preset of 0 never produces an expiry. The count stays at 0 and the flag stays clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcTick | input | 1 | One-cycle countdown source pulse |
| hzTick | input | 1 | One-cycle pulse at 128 Hz |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address (0 preset, 1 control, 2 flag) |
| wrData | input | DATA_W | Write data |
| extIrq | input | 1 | Interrupt request from other sources |
| countValue | output | CNT_W | Current count |
| eventFlag | output | 1 | Sticky expiry flag |
| timerIrq | output | 1 | Timer interrupt pending |
| intOeN | output | 1 | Active-low drive enable of the open-drain interrupt pin |

## Verification
The assertions assume that `srcTick` and `hzTick` are single-cycle pulses in the clock domain, and that a write lasts exactly one cycle at one address. Under those assumptions, a cycle with neither a load nor a step is one in which the counter must stay still. The stimulus drives every input at the falling edge, so each cycle carries at most one write. Ticks are placed individually, so that pause, reload and cancel writes can be made to coincide with a tick on purpose.

// File: rtl/fct_pkg.sv
package fct_pkg;
  localparam int BIT_ENABLE = 0;
  localparam int BIT_RUN    = 1;
  localparam int BIT_RELOAD = 2;
  localparam int BIT_IRQEN  = 3;
  localparam int CTRL_BITS  = 4;

  typedef enum logic [1:0] {
    ADDR_PRESET = 2'd0,
    ADDR_CTRL   = 2'd1,
    ADDR_FLAG   = 2'd2
  } reg_addr_e;

  typedef struct packed {
    logic presetWr;
    logic loadCount;
    logic stepCount;
  } dp_strobe_t;
endpackage

// File: rtl/fct_control.sv
module fct_control
  import fct_pkg::*;
#(
  parameter int HOLD_PERIODS = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 srcTick,
  input  logic                 hzTick,
  input  logic                 wrEn,
  input  logic [1:0]           wrAddr,
  input  logic [CTRL_BITS-1:0] ctrlBits,
  input  logic                 expire,
  output dp_strobe_t           strobe,
  output logic                 eventFlag,
  output logic                 timerIrq
);
  localparam int HOLD_W = $clog2(HOLD_PERIODS + 1);

  logic              enableQ, runQ, irqEnQ;
  logic [HOLD_W-1:0] holdCnt;
  logic              ctrlWr, flagClr, reloadReq, cancelReq;

  always_comb begin
    ctrlWr    = wrEn && (wrAddr == ADDR_CTRL);
    flagClr   = wrEn && (wrAddr == ADDR_FLAG) && !ctrlBits[0];
    reloadReq = ctrlWr && ctrlBits[BIT_RELOAD];
    cancelReq = ctrlWr && !ctrlBits[BIT_IRQEN];
    strobe.presetWr  = wrEn && (wrAddr == ADDR_PRESET);
    strobe.loadCount = !enableQ || reloadReq;
    strobe.stepCount = enableQ && runQ && srcTick && !reloadReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= 1'b0;
      runQ    <= 1'b0;
      irqEnQ  <= 1'b0;
    end else if (ctrlWr) begin
      enableQ <= ctrlBits[BIT_ENABLE];
      runQ    <= ctrlBits[BIT_RUN];
      irqEnQ  <= ctrlBits[BIT_IRQEN];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        eventFlag <= 1'b0;
    else if (expire)  eventFlag <= 1'b1;
    else if (flagClr) eventFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerIrq <= 1'b0;
      holdCnt  <= '0;
    end else if (cancelReq) begin
      timerIrq <= 1'b0;
      holdCnt  <= '0;
    end else if (expire && irqEnQ) begin
      timerIrq <= 1'b1;
      holdCnt  <= '0;
    end else if (timerIrq && hzTick) begin
      if (holdCnt == HOLD_W'(HOLD_PERIODS)) begin
        timerIrq <= 1'b0;
        holdCnt  <= '0;
      end else begin
        holdCnt <= holdCnt + 1'b1;
      end
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    eventFlag && !flagClr |=> eventFlag); // R6
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timerIrq) |-> $past(irqEnQ)); // R7
  AST_IRQ_CANCEL: assert property (@(posedge clk) disable iff (!rstN)
    cancelReq |=> !timerIrq); // R10
  AST_HOLD_MIN: assert property (@(posedge clk) disable iff (!rstN)
    timerIrq && (holdCnt != HOLD_W'(HOLD_PERIODS)) && !cancelReq |=> timerIrq); // R8
endmodule

// File: rtl/fct_datapath.sv
module fct_datapath
  import fct_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_strobe_t       strobe,
  input  logic [CNT_W-1:0] presetIn,
  output logic             expire,
  output logic [CNT_W-1:0] countQ
);
  logic [CNT_W-1:0] presetQ, presetNext;

  always_comb begin
    presetNext = strobe.presetWr ? presetIn : presetQ;
    expire     = strobe.stepCount && (presetQ != '0) && (countQ <= CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                presetQ <= '0;
    else if (strobe.presetWr) presetQ <= presetIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 countQ <= '0;
    else if (strobe.loadCount) countQ <= presetNext;
    else if (strobe.stepCount) begin
      if (expire)              countQ <= presetQ;
      else if (countQ != '0)   countQ <= countQ - 1'b1;
    end
  end

  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadCount && !strobe.stepCount |=> $stable(countQ)); // R3
  AST_RELOAD_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rstN)
    expire && !strobe.presetWr |=> countQ == presetQ); // R2
endmodule

// File: rtl/fixed_cycle_timer.sv
module fixed_cycle_timer
  import fct_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int DATA_W       = CNT_W,
  parameter int HOLD_PERIODS = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              srcTick,
  input  logic              hzTick,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              extIrq,
  output logic [CNT_W-1:0]  countValue,
  output logic              eventFlag,
  output logic              timerIrq,
  output logic              intOeN
);
  dp_strobe_t strobe;
  logic       expire;

  fct_control #(.HOLD_PERIODS(HOLD_PERIODS)) u_control (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .hzTick(hzTick),
    .wrEn(wrEn), .wrAddr(wrAddr), .ctrlBits(wrData[CTRL_BITS-1:0]),
    .expire(expire), .strobe(strobe), .eventFlag(eventFlag), .timerIrq(timerIrq)
  );

  fct_datapath #(.CNT_W(CNT_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .presetIn(wrData[CNT_W-1:0]),
    .expire(expire), .countQ(countValue)
  );

  assign intOeN = !(timerIrq || extIrq);

  AST_PIN_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (timerIrq || extIrq) |-> !intOeN); // R11
endmodule

// File: tb/fixed_cycle_timer_bench.sv
module fixed_cycle_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 27;

  logic clk = 1'b0, rstN = 1'b0, srcTick = 1'b0, hzTick = 1'b0, wrEn = 1'b0, extIrq = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'd0, countValue;
  logic eventFlag, timerIrq, intOeN;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fixed_cycle_timer u_fixed_cycle_timer (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .hzTick(hzTick), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .extIrq(extIrq), .countValue(countValue),
    .eventFlag(eventFlag), .timerIrq(timerIrq), .intOeN(intOeN)
  );

  // {tag4, wr, addr2, data8, src, hz, ext, expCount8, expFlag, expIrq, expOeN}
  localparam logic [28:0] VEC [NVEC] = '{
    {4'd5, 1'b1,2'd0,8'd3,  1'b0,1'b0,1'b0, 8'd3,1'b0,1'b0,1'b1},
    {4'd5, 1'b1,2'd1,8'h0B, 1'b0,1'b0,1'b0, 8'd3,1'b0,1'b0,1'b1},
    {4'd2, 1'b0,2'd0,8'd0,  1'b1,1'b0,1'b0, 8'd2,1'b0,1'b0,1'b1},
    {4'd2, 1'b0,2'd0,8'd0,  1'b1,1'b0,1'b0, 8'd1,1'b0,1'b0,1'b1},
    {4'd2, 1'b0,2'd0,8'd0,  1'b0,1'b0,1'b0, 8'd1,1'b0,1'b0,1'b1},
    {4'd7, 1'b0,2'd0,8'd0,  1'b1,1'b0,1'b0, 8'd3,1'b1,1'b1,1'b0},
    {4'd8, 1'b0,2'd0,8'd0,  1'b0,1'b1,1'b0, 8'd3,1'b1,1'b1,1'b0},
    {4'd9, 1'b1,2'd2,8'd0,  1'b0,1'b0,1'b0, 8'd3,1'b0,1'b1,1'b0},
    {4'd8, 1'b0,2'd0,8'd0,  1'b0,1'b1,1'b0, 8'd3,1'b0,1'b0,1'b1},
    {4'd11,1'b0,2'd0,8'd0,  1'b0,1'b0,1'b1, 8'd3,1'b0,1'b0,1'b0},
    {4'd3, 1'b1,2'd1,8'h09, 1'b0,1'b0,1'b0, 8'd3,1'b0,1'b0,1'b1},
    {4'd3, 1'b0,2'd0,8'd0,  1'b1,1'b0,1'b0, 8'd3,1'b0,1'b0,1'b1},
    {4'd3, 1'b1,2'd1,8'h0B, 1'b1,1'b0,1'b0, 8'd3,1'b0,1'b0,1'b1},
    {4'd3, 1'b0,2'd0,8'd0,  1'b1,1'b0,1'b0, 8'd2,1'b0,1'b0,1'b1},
    {4'd4, 1'b1,2'd1,8'h0F, 1'b1,1'b0,1'b0, 8'd3,1'b0,1'b0,1'b1},
    {4'd4, 1'b0,2'd0,8'd0,  1'b1,1'b0,1'b0, 8'd2,1'b0,1'b0,1'b1},
    {4'd2, 1'b0,2'd0,8'd0,  1'b1,1'b0,1'b0, 8'd1,1'b0,1'b0,1'b1},
    {4'd7, 1'b0,2'd0,8'd0,  1'b1,1'b0,1'b0, 8'd3,1'b1,1'b1,1'b0},
    {4'd6, 1'b1,2'd2,8'd1,  1'b0,1'b0,1'b0, 8'd3,1'b1,1'b1,1'b0},
    {4'd10,1'b1,2'd1,8'h03, 1'b0,1'b0,1'b0, 8'd3,1'b1,1'b0,1'b1},
    {4'd11,1'b0,2'd0,8'd0,  1'b0,1'b0,1'b1, 8'd3,1'b1,1'b0,1'b0},
    {4'd2, 1'b0,2'd0,8'd0,  1'b1,1'b0,1'b0, 8'd2,1'b1,1'b0,1'b1},
    {4'd2, 1'b0,2'd0,8'd0,  1'b1,1'b0,1'b0, 8'd1,1'b1,1'b0,1'b1},
    {4'd7, 1'b0,2'd0,8'd0,  1'b1,1'b0,1'b0, 8'd3,1'b1,1'b0,1'b1},
    {4'd5, 1'b1,2'd1,8'h00, 1'b1,1'b0,1'b0, 8'd2,1'b1,1'b0,1'b1},
    {4'd5, 1'b0,2'd0,8'd0,  1'b1,1'b0,1'b0, 8'd3,1'b1,1'b0,1'b1},
    {4'd5, 1'b0,2'd0,8'd0,  1'b1,1'b0,1'b0, 8'd3,1'b1,1'b0,1'b1}
  };

  function automatic string reqName(input logic [3:0] n);
    case (n)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; 4'd11: return "R11"; 4'd12: return "R12";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic [1:0] a, input logic [7:0] d,
                     input logic s, input logic h, input logic e);
    @(negedge clk);
    wrEn = w; wrAddr = a; wrData = d; srcTick = s; hzTick = h; extIrq = e;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", "count", countValue, 0);
    check("R1", "flag", eventFlag, 0);
    check("R1", "irq", timerIrq, 0);
    check("R1", "oeN", intOeN, 1);
    @(negedge clk) rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      logic [28:0] v;
      string r;
      v = VEC[i];
      r = reqName(v[28:25]);
      cyc(v[24], v[23:22], v[21:14], v[13], v[12], v[11]);
      check(r, $sformatf("row %0d count", i), countValue, v[10:3]);
      check(r, $sformatf("row %0d flag", i), eventFlag, v[2]);
      check(r, $sformatf("row %0d irq", i), timerIrq, v[1]);
      check(r, $sformatf("row %0d oeN", i), intOeN, v[0]);
    end

    // R12: preset 0 never expires
    cyc(1, 2'd2, 8'd0, 0, 0, 0);
    cyc(1, 2'd0, 8'd0, 0, 0, 0);
    check("R12", "count after zero preset", countValue, 0);
    cyc(1, 2'd1, 8'h0B, 0, 0, 0);
    for (int k = 0; k < 6; k++) cyc(0, 2'd0, 8'd0, 1, 0, 0);
    check("R12", "count", countValue, 0);
    check("R12", "flag", eventFlag, 0);
    check("R12", "irq", timerIrq, 0);

    // R5: preset written while disabled shows at once; restart from preset
    cyc(1, 2'd1, 8'h00, 0, 0, 0);
    cyc(1, 2'd0, 8'd5, 0, 0, 0);
    check("R5", "count follows new preset", countValue, 5);
    cyc(1, 2'd1, 8'h03, 0, 0, 0);
    cyc(0, 2'd0, 8'd0, 1, 0, 0);
    cyc(0, 2'd0, 8'd0, 1, 0, 0);
    check("R2", "count after two ticks", countValue, 3);
    cyc(1, 2'd1, 8'h00, 0, 0, 0);
    cyc(1, 2'd1, 8'h03, 0, 0, 0);
    check("R5", "restart from preset", countValue, 5);

    // R6: expiry sets flag that survives a write of 1
    for (int k = 0; k < 5; k++) cyc(0, 2'd0, 8'd0, 1, 0, 0);
    check("R6", "flag on expiry", eventFlag, 1);
    check("R7", "no irq when disabled", timerIrq, 0);
    cyc(1, 2'd2, 8'd1, 0, 0, 0);
    check("R6", "flag ignores write 1", eventFlag, 1);
    cyc(1, 2'd2, 8'd0, 0, 0, 0);
    check("R6", "flag cleared by write 0", eventFlag, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule